// File: doc/BRIEF.md
# Paired-Register Packed Integer SIMD Unit

This block is a 64-bit packed-integer execution unit with eight 64-bit registers. Each operation names a first register. A second register, its partner, is implied: the partner index is the first index with its lowest bit flipped. The second operand comes either from a named register or from a 64-bit memory-data input. Each operation writes one whole register. Depending on the operation, that register is the first register or the partner, and the partner can also serve as an accumulator or as a per-byte condition source.

The operations are:
- an unsigned byte average;
- saturating signed word add and subtract;
- a signed word magnitude maximum;
- an unsigned byte absolute-difference accumulate;
- a rounded signed word multiply-high, in three forms: write to the first register, write to the partner, or add into the partner;
- four per-byte conditional loads keyed on the signs of the partner's bytes.

Decode and memory access are handled elsewhere. A combinational read-back port exposes any register for checking.

Top module: `pair_simd_alu`

## Requirements
- R1: The partner of first index `ra` is `ra ^ 1`. The add, subtract, distance-accumulate, multiply-to-partner and multiply-accumulate operations (op 1, 2, 4, 6, 7) write only the partner and leave register `ra` unchanged.
- R2: op 0 writes, into each byte of `ra`, the value (a+b)>>1. The bytes are treated as unsigned and summed at 9 bits.
- R3: op 1 writes the signed 16-bit sum a+b to the partner, and op 2 writes the signed difference a−b. Each word lane saturates to the range 0x8000..0x7FFF.
- R4: op 3 replaces each signed word lane of `ra` with the second operand's lane when |b| > |a|. The magnitude of 0x8000 is taken as 32768, and on equal magnitudes the lane is kept.
- R5: op 4 adds |a−b| of each unsigned byte to the partner's byte and clamps the result at 0xFF.
- R6: The rounded product r = (a*b+0x4000)>>15 is computed on signed word lanes. The low 16 bits are kept, with no saturation. op 5 writes r to `ra`, op 6 writes r to the partner, and op 7 adds r into the partner's lane with 16-bit wrap.
- R7: ops 8, 9, 10 and 11 copy a byte of the memory operand into `ra` only where the partner's byte, read as signed, is =0, ≠0, <0 or ≥0 respectively. All other bytes are kept.
- R8: ops 4, 7, 8, 9, 10 and 11 need `use_mem`=1. When such an op is issued with `use_mem`=0, `err` is 1 in the next cycle and no register changes.
- R9: Opcodes 12 to 15 are illegal. Issuing one sets `err` in the next cycle and writes nothing. A legal op clears `err` and its result is readable after the next rising edge. With `issue`=0 no register changes.
- R10: Reset clears all registers and `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Operation valid this cycle |
| op | input | 4 | Operation code |
| ra | input | 3 | First register index |
| rb | input | 3 | Second-operand register index |
| use_mem | input | 1 | Take the second operand from `mem_data` |
| mem_data | input | 64 | Memory-side second operand |
| rd_idx | input | 3 | Read-back register index |
| rd_data | output | 64 | Read-back register value |
| err | output | 1 | Previous issue was illegal or lacked its memory operand |

## Verification
The random operand generator favours the byte values 0x00, 0x7F, 0x80 and 0xFF. This drives word lanes onto both saturation rails, onto the 0x8000 magnitude tie and onto the negative rounding case of the multiply. Conditional moves therefore meet zero, positive and negative partner bytes in the same word.

Directed sequences target one case each:
- register partners, to show the result lands on `ra^1` and not on `ra`;
- repeated distance accumulates, which separate clamping from wrapping;
- a chained byte average, which shows the ninth sum bit is kept;
- illegal or register-sourced forms, which must leave every register untouched.

// File: rtl/pair_simd_alu.sv
module pair_simd_alu #(
  parameter int NREG = 8,
  parameter int W    = 64,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [3:0]    op,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  input  logic          use_mem,
  input  logic [W-1:0]  mem_data,
  input  logic [AW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic          err
);
  localparam int NB = W / 8;
  localparam int NH = W / 16;

  localparam logic [3:0] OP_AVG  = 4'd0, OP_ADDS = 4'd1, OP_SUBS = 4'd2, OP_MAG  = 4'd3,
                         OP_DIST = 4'd4, OP_MULA = 4'd5, OP_MULP = 4'd6, OP_MAC  = 4'd7,
                         OP_MVZ  = 4'd8, OP_MVNZ = 4'd9, OP_MVLZ = 4'd10, OP_MVGE = 4'd11;

  logic [NREG-1:0][W-1:0] rf;
  logic [AW-1:0] pa;
  logic [W-1:0]  a, b, p, res;
  logic legal, mem_req, bad, to_partner;

  assign pa         = ra ^ AW'(1);
  assign a          = rf[ra];
  assign p          = rf[pa];
  assign b          = use_mem ? mem_data : rf[rb];
  assign rd_data    = rf[rd_idx];
  assign legal      = op <= OP_MVGE;
  assign mem_req    = (op == OP_DIST) || (op == OP_MAC) || (op >= OP_MVZ);
  assign bad        = !legal || (mem_req && !use_mem);
  assign to_partner = (op == OP_ADDS) || (op == OP_SUBS) || (op == OP_DIST) ||
                      (op == OP_MULP) || (op == OP_MAC);

  always_comb begin
    logic [8:0]         s9;
    logic signed [16:0] s17, xa, xb;
    logic [16:0]        ma, mb;
    logic signed [31:0] rnd;
    logic [15:0]        mh;
    logic [7:0]         d8;
    logic               hit;
    res = a;
    if (op == OP_AVG || op == OP_DIST || op >= OP_MVZ) begin
      for (int i = 0; i < NB; i++) begin
        case (op)
          OP_AVG: begin
            s9 = {1'b0, a[8*i +: 8]} + {1'b0, b[8*i +: 8]};
            res[8*i +: 8] = 8'(s9 >> 1);
          end
          OP_DIST: begin
            d8 = (a[8*i +: 8] > b[8*i +: 8]) ? a[8*i +: 8] - b[8*i +: 8]
                                             : b[8*i +: 8] - a[8*i +: 8];
            s9 = {1'b0, p[8*i +: 8]} + {1'b0, d8};
            res[8*i +: 8] = s9[8] ? 8'hFF : s9[7:0];
          end
          default: begin
            case (op)
              OP_MVZ:  hit = (p[8*i +: 8] == 8'd0);
              OP_MVNZ: hit = (p[8*i +: 8] != 8'd0);
              OP_MVLZ: hit = p[8*i+7];
              default: hit = !p[8*i+7];
            endcase
            res[8*i +: 8] = hit ? b[8*i +: 8] : a[8*i +: 8];
          end
        endcase
      end
    end else begin
      for (int i = 0; i < NH; i++) begin
        xa  = $signed({a[16*i+15], a[16*i +: 16]});
        xb  = $signed({b[16*i+15], b[16*i +: 16]});
        rnd = $signed(a[16*i +: 16]) * $signed(b[16*i +: 16]) + 32'sh4000;
        mh  = 16'(rnd >>> 15);
        case (op)
          OP_ADDS, OP_SUBS: begin
            s17 = (op == OP_ADDS) ? xa + xb : xa - xb;
            if (s17 > 17'sd32767)       res[16*i +: 16] = 16'h7FFF;
            else if (s17 < -17'sd32768) res[16*i +: 16] = 16'h8000;
            else                        res[16*i +: 16] = s17[15:0];
          end
          OP_MAG: begin
            ma = xa[16] ? 17'(-xa) : 17'(xa);
            mb = xb[16] ? 17'(-xb) : 17'(xb);
            res[16*i +: 16] = (mb > ma) ? b[16*i +: 16] : a[16*i +: 16];
          end
          OP_MAC:  res[16*i +: 16] = p[16*i +: 16] + mh;
          default: res[16*i +: 16] = mh;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf  <= '0;
      err <= 1'b0;
    end else begin
      err <= issue && bad;
      if (issue && !bad) rf[to_partner ? pa : ra] <= res;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(rf)); // R9
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !legal |=> $stable(rf) && err); // R9
  AST_MEM_MISSING_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    issue && legal && mem_req && !use_mem |=> $stable(rf) && err); // R8
  AST_ERR_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(issue)); // R8
  AST_PARTNER_SPARES_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !bad && to_partner |=> rf[$past(ra)] == $past(rf[ra])); // R1

  for (genvar g = 0; g < NB; g++) begin : g_dist_chk
    AST_DIST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      issue && !bad && op == OP_DIST |=> rf[$past(pa)][8*g +: 8] >= $past(p[8*g +: 8])); // R5
  end
endmodule

// File: tb/tb_pair_simd_alu.sv
`timescale 1ns/1ps
module tb_pair_simd_alu;
  logic        clk = 0, rst_n = 0, issue = 0, use_mem = 0;
  logic [3:0]  op = 0;
  logic [2:0]  ra = 0, rb = 0, rd_idx = 0;
  logic [63:0] mem_data = 0, rd_data;
  logic        err;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [63:0] m [8];
  logic exp_err = 0;

  always #2 clk = ~clk;

  pair_simd_alu dut (.clk, .rst_n, .issue, .op, .ra, .rb, .use_mem, .mem_data,
                     .rd_idx, .rd_data, .err);

  task automatic chk(logic [63:0] act, logic [63:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(int o, bit um);
    if (o > 11) return "R9";
    if (!um && (o == 4 || o == 7 || o >= 8)) return "R8";
    case (o)
      0: return "R2";
      1, 2: return "R1/R3";
      3: return "R4";
      4: return "R1/R5";
      5, 6, 7: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [63:0] ref_res(int o, logic [63:0] a, logic [63:0] b, logic [63:0] p);
    logic [63:0] r = a;
    for (int i = 0; i < 8; i++) begin
      int ua = a[8*i +: 8], ub = b[8*i +: 8], up = p[8*i +: 8], t;
      int sp = $signed(p[8*i +: 8]);
      bit take;
      case (o)
        0: r[8*i +: 8] = 8'((ua + ub) / 2);
        4: begin
          t = up + ((ua > ub) ? ua - ub : ub - ua);
          r[8*i +: 8] = 8'((t > 255) ? 255 : t);
        end
        8, 9, 10, 11: begin
          take = (o == 8) ? (sp == 0) : (o == 9) ? (sp != 0) : (o == 10) ? (sp < 0) : (sp >= 0);
          if (take) r[8*i +: 8] = b[8*i +: 8];
        end
        default: ;
      endcase
    end
    for (int i = 0; i < 4; i++) begin
      int sa = $signed(a[16*i +: 16]), sb = $signed(b[16*i +: 16]), t;
      longint pr;
      pr = longint'(sa) * longint'(sb);
      pr = (pr + 16384) >>> 15;
      case (o)
        1, 2: begin
          t = (o == 1) ? sa + sb : sa - sb;
          if (t > 32767) t = 32767;
          if (t < -32768) t = -32768;
          r[16*i +: 16] = 16'(t);
        end
        3: if ((sb < 0 ? -sb : sb) > (sa < 0 ? -sa : sa)) r[16*i +: 16] = b[16*i +: 16];
        5, 6: r[16*i +: 16] = 16'(pr);
        7: r[16*i +: 16] = 16'(longint'(p[16*i +: 16]) + pr);
        default: ;
      endcase
    end
    return r;
  endfunction

  task automatic read_all(string tag);
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      #0.1;
      chk(rd_data, m[i], $sformatf("%s reg%0d", tag, i));
    end
  endtask

  task automatic do_op(int o, int fa, int fb, bit um, logic [63:0] md);
    logic [63:0] bv;
    int dst;
    bit needm, bad;
    @(negedge clk);
    issue = 1; op = 4'(o); ra = 3'(fa); rb = 3'(fb); use_mem = um; mem_data = md;
    needm = (o == 4 || o == 7 || o >= 8);
    bad = (o > 11) || (needm && !um);
    bv = um ? md : m[fb];
    exp_err = bad;
    if (!bad) begin
      dst = (o == 1 || o == 2 || o == 4 || o == 6 || o == 7) ? (fa ^ 1) : fa;
      m[dst] = ref_res(o, m[fa], bv, m[fa ^ 1]);
    end
    @(negedge clk);
    issue = 0;
    chk({63'd0, err}, {63'd0, exp_err}, {tag_of(o, um), " err"});
    read_all(tag_of(o, um));
  endtask

  function automatic logic [63:0] rnd_word();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) begin
      case ($urandom_range(0, 5))
        0: v[8*i +: 8] = 8'h00;
        1: v[8*i +: 8] = 8'h7F;
        2: v[8*i +: 8] = 8'h80;
        3: v[8*i +: 8] = 8'hFF;
        default: v[8*i +: 8] = 8'($urandom);
      endcase
    end
    return v;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expected=finish actual=hang");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 8; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({63'd0, err}, 64'd0, "R10 err");
    read_all("R10");

    do_op(1, 0, 0, 1, 64'h7FFF_8000_0001_FFFF);
    chk(m[1], 64'h7FFF_8000_0001_FFFF, "R1 model");
    do_op(1, 1, 0, 1, 64'h0001_FFFF_7FFF_8000);
    rd_idx = 0; #0.1;
    chk(rd_data, 64'h7FFF_8000_7FFF_8000, "R3 saturate");
    do_op(3, 0, 0, 1, 64'h8000_7FFF_0001_8000);
    rd_idx = 0; #0.1;
    chk(rd_data, 64'h8000_8000_7FFF_8000, "R4 magnitude");

    do_op(1, 2, 0, 1, 64'h8000_8000_8000_8000);
    do_op(5, 3, 0, 1, 64'h8000_8000_8000_8000);
    rd_idx = 3; #0.1;
    chk(rd_data, 64'h8000_8000_8000_8000, "R6 min squared");
    do_op(6, 3, 0, 1, 64'h4000_4000_4000_4000);
    rd_idx = 2; #0.1;
    chk(rd_data, 64'hC000_C000_C000_C000, "R6 to partner");

    do_op(14, 0, 0, 1, 64'h1);
    do_op(4, 0, 0, 0, 64'h0);
    do_op(8, 2, 1, 0, 64'h0);

    do_op(4, 4, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    do_op(4, 4, 0, 1, 64'h0101_0101_0101_0101);
    rd_idx = 5; #0.1;
    chk(rd_data, 64'hFFFF_FFFF_FFFF_FFFF, "R5 clamp");
    do_op(0, 4, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    do_op(0, 4, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_idx = 4; #0.1;
    chk(rd_data, 64'hBFBF_BFBF_BFBF_BFBF, "R2 ninth bit");

    do_op(1, 7, 0, 1, 64'h0001_80FF_007F_8100);
    do_op(8, 7, 0, 1, 64'hAAAA_AAAA_AAAA_AAAA);
    rd_idx = 7; #0.1;
    chk(rd_data, 64'hAA00_0000_AA00_00AA, "R7 zero");
    do_op(10, 7, 0, 1, 64'h5555_5555_5555_5555);
    rd_idx = 7; #0.1;
    chk(rd_data, 64'hAA00_5555_AA00_55AA, "R7 negative");

    @(negedge clk);
    @(negedge clk);
    read_all("R9 idle");

    for (int n = 0; n < 700; n++)
      do_op($urandom_range(0, 13), $urandom_range(0, 7), $urandom_range(0, 7),
            $urandom_range(0, 3) != 0, rnd_word());

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule